// File: doc/BRIEF.md
# Register/Memory Move Instruction Decoder

This block takes the bytes of a 16-bit register/memory move instruction one at a time over a valid/ready byte stream. It checks the leading opcode byte and then reads the operand-format byte. Depending on the mode field, it collects zero, one or two displacement bytes. Once the last byte of the instruction has arrived, it presents a decoded record for one cycle, marked by a completion pulse.

The record holds the following:
- the transfer direction and the operand width;
- the register operand code;
- a flag that says whether the second operand is a register or memory;
- the second register code;
- a memory descriptor that names the base register, the index register and a direct-address flag;
- the displacement, extended to 16 bits;
- the default segment selection, stack or data.

An execution or address-generation stage uses this record. The block does not compute effective addresses and does not read the register file.

Top module: `movrm_decoder`

## Requirements
- R1: First bytes 0x88 to 0x8B are accepted. In the record, `dir_to_reg` equals opcode bit 1 (1 = register field is destination) and `wide` equals opcode bit 0 (1 = 16-bit operands).
- R2: Any other first byte produces a one-cycle `dec_err` pulse in the cycle after it is accepted. No `dec_done` follows, and the next byte is treated as a new opcode.
- R3: The second byte supplies mode in bits 7:6, `reg_code` from bits 5:3 and `rm_code` from bits 2:0. With mode 11, `rm_is_reg` is 1, no displacement byte is read, `disp` is 0, the base and index selections are none, and the data segment is used.
- R4: With mode 00 and rm other than 110, no displacement byte is read. `dec_done` rises in the cycle after the second byte is accepted, and `disp` is 0.
- R5: Mode 00 with rm 110 is a direct address. Two further bytes are read, low byte first, into `disp`. `direct_addr` is 1, base and index are none, and the data segment is used.
- R6: Mode 01 reads one byte, which is sign-extended into `disp` (0x80 gives 0xFF80, 0x7F gives 0x007F).
- R7: Mode 10 reads two bytes, low byte first, into `disp`.
- R8: For memory modes, rm maps to `base_sel`/`index_sel` (base: 0 none, 1 BX, 2 BP; index: 0 none, 1 SI, 2 DI) as follows: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP (when not direct), 111 BX.
- R9: `use_stack_seg` is 1 exactly when the memory operand uses BP as base. It is 0 for all other memory forms and for register forms.
- R10: `dec_done` is high for exactly one cycle, and `in_ready` is low in that cycle only. The record outputs keep their values until the next instruction completes.
- R11: Outside the completion cycle `in_ready` is 1. A cycle with `in_valid` low consumes no byte and advances nothing.
- R12: During and right after reset, `dec_done` and `dec_err` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| dec_done | output | 1 | One-cycle pulse: record is complete |
| dec_err | output | 1 | One-cycle pulse: unsupported opcode seen |
| dir_to_reg | output | 1 | Register field is the destination |
| wide | output | 1 | 16-bit operand width |
| reg_code | output | 3 | Register operand code |
| rm_is_reg | output | 1 | Second operand is a register |
| rm_code | output | 3 | Raw rm field (second register code in register form) |
| base_sel | output | 2 | Base register: 0 none, 1 BX, 2 BP |
| index_sel | output | 2 | Index register: 0 none, 1 SI, 2 DI |
| direct_addr | output | 1 | Displacement is an absolute address |
| disp | output | 16 | Sign-extended displacement |
| use_stack_seg | output | 1 | Default segment is the stack segment |

## Verification
- **Completion timing:** a byte is accepted on a rising edge. `dec_done` and the full record appear one register later, in the cycle right after the last byte of the instruction, whether that is the second, third or fourth byte.
- **Error timing:** `dec_err` appears in the cycle right after a rejected opcode.
- **Sampling:** the bench drives each byte on the falling edge and samples on the next falling edge after acceptance. Every record field is compared there, and the completion flag is confirmed low after each earlier byte.
- **Hold and stall checks:** record hold and stalled cycles are checked some falling edges later, with no byte offered in between.

// File: rtl/mvd_pkg.sv
package mvd_pkg;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_BX   = 2'd1,
        BASE_BP   = 2'd2
    } base_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_SI   = 2'd1,
        IDX_DI   = 2'd2
    } idx_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_MODRM   = 3'd1,
        ST_DISP_LO = 3'd2,
        ST_DISP_HI = 3'd3,
        ST_DONE    = 3'd4
    } st_e;

    // operand description derived from the second byte
    typedef struct packed {
        base_e      base;
        idx_e       index;
        logic       direct;
        logic       stack;
        logic       is_reg;
        logic [1:0] disp_len;
    } mem_desc_t;

endpackage

// File: rtl/mvd_opcode_chk.sv
module mvd_opcode_chk #(
    parameter int BYTE_W    = 8,
    parameter int OPC_BASE  = 'h88,
    parameter int OPC_COUNT = 4
) (
    input  logic [BYTE_W-1:0] op,
    output logic              legal,
    output logic              dir,
    output logic              wide
);
    localparam int OPC_LAST = OPC_BASE + OPC_COUNT - 1;

    always_comb begin
        legal = (int'(op) >= OPC_BASE) && (int'(op) <= OPC_LAST);
        dir   = op[1];
        wide  = op[0];
    end
endmodule

// File: rtl/mvd_modrm_dec.sv
module mvd_modrm_dec
    import mvd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] modrm,
    output mem_desc_t         desc,
    output logic [2:0]        reg_code,
    output logic [2:0]        rm_code
);
    logic [1:0] mode;
    logic [2:0] rm;

    always_comb begin
        mode     = modrm[7:6];
        rm       = modrm[2:0];
        reg_code = modrm[5:3];
        rm_code  = rm;

        desc          = '0;
        desc.base     = BASE_NONE;
        desc.index    = IDX_NONE;
        desc.is_reg   = (mode == 2'b11);

        if (mode != 2'b11) begin
            case (rm)
                3'b000: begin desc.base = BASE_BX; desc.index = IDX_SI; end
                3'b001: begin desc.base = BASE_BX; desc.index = IDX_DI; end
                3'b010: begin desc.base = BASE_BP; desc.index = IDX_SI; end
                3'b011: begin desc.base = BASE_BP; desc.index = IDX_DI; end
                3'b100: desc.index = IDX_SI;
                3'b101: desc.index = IDX_DI;
                3'b110: begin
                    if (mode == 2'b00) desc.direct = 1'b1;
                    else               desc.base   = BASE_BP;
                end
                default: desc.base = BASE_BX;
            endcase
            desc.stack = (desc.base == BASE_BP);
        end

        case (mode)
            2'b00:   desc.disp_len = (rm == 3'b110) ? 2'd2 : 2'd0;
            2'b01:   desc.disp_len = 2'd1;
            2'b10:   desc.disp_len = 2'd2;
            default: desc.disp_len = 2'd0;
        endcase
    end
endmodule

// File: rtl/mvd_disp_acc.sv
module mvd_disp_acc #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_lo,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic [2*BYTE_W-1:0] disp_one,
    output logic [2*BYTE_W-1:0] disp_two
);
    logic [BYTE_W-1:0] lo_d, lo_q;

    always_comb begin
        lo_d     = cap_lo ? byte_in : lo_q;
        disp_one = {{BYTE_W{byte_in[BYTE_W-1]}}, byte_in};
        disp_two = {byte_in, lo_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lo_q <= '0;
        else        lo_q <= lo_d;
    end

    // R7: the low byte of a two-byte displacement is kept until the high byte
    a_r7_lo_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_lo |=> lo_q == $past(byte_in));
endmodule

// File: rtl/movrm_decoder.sv
module movrm_decoder
    import mvd_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int OPC_BASE  = 'h88,
    parameter int OPC_COUNT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_byte,
    output logic                in_ready,
    output logic                dec_done,
    output logic                dec_err,
    output logic                dir_to_reg,
    output logic                wide,
    output logic [2:0]          reg_code,
    output logic                rm_is_reg,
    output logic [2:0]          rm_code,
    output logic [1:0]          base_sel,
    output logic [1:0]          index_sel,
    output logic                direct_addr,
    output logic [2*BYTE_W-1:0] disp,
    output logic                use_stack_seg
);
    localparam int DISP_W = 2 * BYTE_W;

    typedef struct packed {
        logic              dir;
        logic              wide;
        logic [2:0]        reg_code;
        logic [2:0]        rm_code;
        mem_desc_t         desc;
        logic [DISP_W-1:0] disp;
    } rec_t;

    typedef struct packed {
        st_e  st;
        logic err;
        rec_t pend;
        rec_t rec;
    } ctl_t;

    ctl_t d_d, d_q;

    logic              accept;
    logic              opc_legal, opc_dir, opc_wide;
    mem_desc_t         mr_desc;
    logic [2:0]        mr_reg, mr_rm;
    logic              cap_lo;
    logic [DISP_W-1:0] disp_one, disp_two;

    mvd_opcode_chk #(
        .BYTE_W(BYTE_W), .OPC_BASE(OPC_BASE), .OPC_COUNT(OPC_COUNT)
    ) u_opc (
        .op(in_byte), .legal(opc_legal), .dir(opc_dir), .wide(opc_wide)
    );

    mvd_modrm_dec #(.BYTE_W(BYTE_W)) u_modrm (
        .modrm(in_byte), .desc(mr_desc), .reg_code(mr_reg), .rm_code(mr_rm)
    );

    mvd_disp_acc #(.BYTE_W(BYTE_W)) u_disp (
        .clk(clk), .rst_n(rst_n), .cap_lo(cap_lo), .byte_in(in_byte),
        .disp_one(disp_one), .disp_two(disp_two)
    );

    always_comb begin
        in_ready = (d_q.st != ST_DONE);
        accept   = in_valid && in_ready;
        cap_lo   = accept && (d_q.st == ST_DISP_LO) && (d_q.pend.desc.disp_len == 2'd2);

        d_d     = d_q;
        d_d.err = 1'b0;

        case (d_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (opc_legal) begin
                        d_d.st        = ST_MODRM;
                        d_d.pend.dir  = opc_dir;
                        d_d.pend.wide = opc_wide;
                    end else begin
                        d_d.err = 1'b1;
                    end
                end
            end
            ST_MODRM: begin
                if (accept) begin
                    d_d.pend.reg_code = mr_reg;
                    d_d.pend.rm_code  = mr_rm;
                    d_d.pend.desc     = mr_desc;
                    d_d.pend.disp     = '0;
                    if (mr_desc.disp_len == 2'd0) begin
                        d_d.rec      = d_d.pend;
                        d_d.st       = ST_DONE;
                    end else begin
                        d_d.st       = ST_DISP_LO;
                    end
                end
            end
            ST_DISP_LO: begin
                if (accept) begin
                    if (d_q.pend.desc.disp_len == 2'd1) begin
                        d_d.pend.disp = disp_one;
                        d_d.rec       = d_d.pend;
                        d_d.st        = ST_DONE;
                    end else begin
                        d_d.st        = ST_DISP_HI;
                    end
                end
            end
            ST_DISP_HI: begin
                if (accept) begin
                    d_d.pend.disp = disp_two;
                    d_d.rec       = d_d.pend;
                    d_d.st        = ST_DONE;
                end
            end
            default: d_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q                <= '0;
            d_q.st             <= ST_IDLE;
            d_q.pend.desc.base <= BASE_NONE;
            d_q.pend.desc.index<= IDX_NONE;
            d_q.rec.desc.base  <= BASE_NONE;
            d_q.rec.desc.index <= IDX_NONE;
        end else begin
            d_q <= d_d;
        end
    end

    always_comb begin
        dec_done      = (d_q.st == ST_DONE);
        dec_err       = d_q.err;
        dir_to_reg    = d_q.rec.dir;
        wide          = d_q.rec.wide;
        reg_code      = d_q.rec.reg_code;
        rm_is_reg     = d_q.rec.desc.is_reg;
        rm_code       = d_q.rec.rm_code;
        base_sel      = d_q.rec.desc.base;
        index_sel     = d_q.rec.desc.index;
        direct_addr   = d_q.rec.desc.direct;
        disp          = d_q.rec.disp;
        use_stack_seg = d_q.rec.desc.stack;
    end

    // R10: completion lasts one cycle and input stalls only during it
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> !dec_done);
    a_r10_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> in_ready);
    // R10: record outputs only move when an instruction completes
    a_r10_record_held: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(disp) && $stable(reg_code) && $stable(base_sel));
    // R2: a rejected opcode never completes
    a_r2_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> !dec_done && in_ready);
    // R3: register form carries no memory descriptor
    a_r3_reg_form_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && rm_is_reg) |-> (disp == '0) && (base_sel == 2'd0)
                                     && (index_sel == 2'd0) && !use_stack_seg);
    // R5: direct addresses use the data segment and no registers
    a_r5_direct_data: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && direct_addr) |-> !use_stack_seg && (base_sel == 2'd0)
                                       && (index_sel == 2'd0));
    // R9: a BP base selects the stack segment
    a_r9_bp_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && !rm_is_reg && base_sel == 2'd2) |-> use_stack_seg);
endmodule

// File: tb/tb_movrm_decoder.sv
module tb_movrm_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, dec_done, dec_err, dir_to_reg, wide, rm_is_reg;
    logic        direct_addr, use_stack_seg;
    logic [2:0]  reg_code, rm_code;
    logic [1:0]  base_sel, index_sel;
    logic [15:0] disp;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    movrm_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .dec_done(dec_done), .dec_err(dec_err),
        .dir_to_reg(dir_to_reg), .wide(wide), .reg_code(reg_code),
        .rm_is_reg(rm_is_reg), .rm_code(rm_code), .base_sel(base_sel),
        .index_sel(index_sel), .direct_addr(direct_addr), .disp(disp),
        .use_stack_seg(use_stack_seg)
    );

    // op, modrm, b2, b3, byte count, base, index, direct, stack, disp
    localparam int NV = 12;
    localparam logic [56:0] VEC [NV] = '{
        {8'h8B, 8'hC3, 8'h00, 8'h00, 3'd2, 2'd0, 2'd0, 1'b0, 1'b0, 16'h0000},
        {8'h88, 8'h00, 8'h00, 8'h00, 3'd2, 2'd1, 2'd1, 1'b0, 1'b0, 16'h0000},
        {8'h89, 8'h0A, 8'h00, 8'h00, 3'd2, 2'd2, 2'd1, 1'b0, 1'b1, 16'h0000},
        {8'h8A, 8'h06, 8'h34, 8'h12, 3'd4, 2'd0, 2'd0, 1'b1, 1'b0, 16'h1234},
        {8'h8B, 8'h46, 8'hF0, 8'h00, 3'd3, 2'd2, 2'd0, 1'b0, 1'b1, 16'hFFF0},
        {8'h88, 8'h4F, 8'h7F, 8'h00, 3'd3, 2'd1, 2'd0, 1'b0, 1'b0, 16'h007F},
        {8'h89, 8'h8B, 8'h78, 8'h56, 3'd4, 2'd2, 2'd2, 1'b0, 1'b1, 16'h5678},
        {8'h8A, 8'h94, 8'h00, 8'h80, 3'd4, 2'd0, 2'd1, 1'b0, 1'b0, 16'h8000},
        {8'h8B, 8'h3D, 8'h00, 8'h00, 3'd2, 2'd0, 2'd2, 1'b0, 1'b0, 16'h0000},
        {8'h8B, 8'h81, 8'hFF, 8'hFF, 3'd4, 2'd1, 2'd2, 1'b0, 1'b0, 16'hFFFF},
        {8'h88, 8'h7E, 8'h80, 8'h00, 3'd3, 2'd2, 2'd0, 1'b0, 1'b1, 16'hFF80},
        {8'h89, 8'hEE, 8'h00, 8'h00, 3'd2, 2'd0, 2'd0, 1'b0, 1'b0, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // drive one byte at a falling edge; it is taken at the following rising edge
    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        chk(in_ready === 1'b1, "R11", "in_ready before byte", 32'(in_ready), 1);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
    endtask

    task automatic run_vec(input logic [56:0] v, input string tag);
        logic [7:0] b [4];
        int nb;
        b[0] = v[56:49]; b[1] = v[48:41]; b[2] = v[40:33]; b[3] = v[32:25];
        nb = int'(v[24:22]);
        for (int k = 0; k < nb; k++) begin
            if (k > 0)
                chk(dec_done === 1'b0, "R4", {tag, " early done"}, 32'(dec_done), 0);
            put_byte(b[k]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(dec_done === 1'b1, "R10", {tag, " done"}, 32'(dec_done), 1);
        chk(in_ready === 1'b0, "R10", {tag, " ready low"}, 32'(in_ready), 0);
        chk(dir_to_reg === b[0][1] && wide === b[0][0], "R1", {tag, " dir/w"},
            32'({dir_to_reg, wide}), 32'(b[0][1:0]));
        chk(reg_code === b[1][5:3] && rm_code === b[1][2:0], "R3", {tag, " reg/rm"},
            32'({reg_code, rm_code}), 32'({b[1][5:3], b[1][2:0]}));
        chk(rm_is_reg === (b[1][7:6] == 2'b11), "R3", {tag, " is_reg"},
            32'(rm_is_reg), 32'(b[1][7:6] == 2'b11));
        chk(base_sel === v[21:20] && index_sel === v[19:18], "R8", {tag, " base/index"},
            32'({base_sel, index_sel}), 32'(v[21:18]));
        chk(direct_addr === v[17], "R5", {tag, " direct"}, 32'(direct_addr), 32'(v[17]));
        chk(use_stack_seg === v[16], "R9", {tag, " segment"}, 32'(use_stack_seg), 32'(v[16]));
        chk(disp === v[15:0], "R6", {tag, " disp (R7)"}, 32'(disp), 32'(v[15:0]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dec_done === 1'b0 && dec_err === 1'b0, "R12", "reset flags",
            32'({dec_done, dec_err}), 0);
        chk(in_ready === 1'b1, "R12", "reset ready", 32'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dec_done === 1'b0 && in_ready === 1'b1, "R12", "after reset",
            32'({dec_done, in_ready}), 1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], $sformatf("vec%0d", i));

        // R2: unsupported opcodes
        put_byte(8'h8C);
        @(negedge clk);
        in_valid = 1'b0;
        chk(dec_err === 1'b1, "R2", "err pulse 8C", 32'(dec_err), 1);
        chk(dec_done === 1'b0, "R2", "no done on 8C", 32'(dec_done), 0);
        @(negedge clk);
        chk(dec_err === 1'b0, "R2", "err one cycle", 32'(dec_err), 0);
        put_byte(8'h87);
        @(negedge clk);
        in_valid = 1'b0;
        chk(dec_err === 1'b1, "R2", "err pulse 87", 32'(dec_err), 1);
        run_vec(VEC[3], "after err R2");

        // R10: record held with no new input
        repeat (5) @(negedge clk);
        chk(dec_done === 1'b0, "R10", "done dropped", 32'(dec_done), 0);
        chk(disp === 16'h1234 && direct_addr === 1'b1, "R10", "record held",
            32'(disp), 32'h1234);

        // R11: stall between displacement bytes
        put_byte(8'h89);
        put_byte(8'h8B);
        put_byte(8'hCD);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(dec_done === 1'b0, "R11", "stall no done", 32'(dec_done), 0);
        chk(disp === 16'h1234, "R11", "stall record", 32'(disp), 32'h1234);
        put_byte(8'hAB);
        @(negedge clk);
        in_valid = 1'b0;
        chk(dec_done === 1'b1, "R11", "done after stall", 32'(dec_done), 1);
        chk(disp === 16'hABCD, "R7", "disp after stall", 32'(disp), 32'hABCD);
        chk(use_stack_seg === 1'b1, "R9", "BP+DI stack", 32'(use_stack_seg), 1);

        // R4: back-to-back short instruction right after completion
        run_vec(VEC[1], "b2b R4");

        summary();
        $finish;
    end
endmodule